// File: doc/BRIEF.md
# Hit Timestamp Buffer with Token Readout

This block is the digital back end that sits behind a bank of detector channels on one chip. A free-running 48-bit counter, kept in Gray code, gives every hit a time with one clock period of resolution. The clock is nominally 80 MHz, which gives 12.5 ns. A channel's discriminator strobe passes through a synchronizer. On the synchronized rising edge, the current Gray count is stored in that channel's buffer. A channel in anodic mode holds up to five records. A channel in cathodic mode holds one.

Stored hits leave the block as 64-bit records, each sent as four 16-bit words. Readout passes a token from chip to chip. A token-go pulse lets this chip send. Channels are visited from the lowest channel ID upward, and the oldest record in a channel goes first. For each word, the block raises data-ready and waits for a one-cycle data-read strobe. When the chip has nothing left to send, it returns a one-cycle token-back pulse. Two flags report whether any anodic or any cathodic buffer still holds unread data.

Top module: `hit_ts_readout`

## Requirements
- R1: The timestamp counter is 48 bits wide, keeps its value in Gray code and advances by one count per clock. Consecutive values differ in exactly one bit.
- R2: The active-low reset is released through two flops, so the counter holds 0 for the first two edges after rst_n rises. A strobe raised after the m-th rising edge since rst_n rose (m >= 2) stores the Gray code of count m. The stored value stays in Gray code.
- R3: A record is, from bit 63 down: timestamp Gray code [63:16], chip ID [15:14], channel ID [13:8], register ID [7:5], mode [4] (1 = anodic, 0 = cathodic), and zeros [3:0].
- R4: A record is sent as four words, most significant first: bits 63:48, then 47:32, then 31:16, then 15:0. data_ready stays high and data_o holds the current word until a data_read strobe takes it.
- R5: An anodic channel stores up to 5 records in slots 0 to 4, in arrival order. The register ID is the slot index, and slots are read oldest first. Slot 0 is reused after the channel has been read empty.
- R6: A cathodic channel stores one record, always in slot 0.
- R7: A hit that arrives at a full channel is dropped, and the records already stored are not changed.
- R8: A channel whose enable input is low records nothing.
- R9: Within one token visit, all stored records are sent in ascending channel ID order.
- R10: After a token_go pulse, the block sends its records and then pulses token_back high for exactly one cycle. With nothing stored, the pulse comes two edges after token_go is sampled. token_back and data_ready are never high together.
- R11: anode_nonempty_o is high while any anodic-mode channel holds an unread record. cathode_nonempty_o is high while any cathodic-mode channel holds one.
- R12: During reset and right after it, data_ready_o, token_back_o, both non-empty flags and data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NCH | Discriminator strobes, one per channel |
| chan_en_i | input | NCH | Channel enables |
| chan_anodic_i | input | NCH | Channel mode, 1 = anodic, 0 = cathodic |
| chip_id_i | input | 2 | Chip identifier placed in every record |
| token_go_i | input | 1 | Token arriving from the previous chip |
| data_read_i | input | 1 | One-cycle strobe that takes the current word |
| data_o | output | 16 | Output word |
| data_ready_o | output | 1 | A word is valid on data_o |
| token_back_o | output | 1 | One-cycle pulse, nothing left to send |
| anode_nonempty_o | output | 1 | Some anodic buffer holds data |
| cathode_nonempty_o | output | 1 | Some cathodic buffer holds data |

## Verification
Some rules are checked by assertions on every cycle:
- Each counter step changes exactly one bit.
- A channel's fill level never goes past its mode's depth.
- A full or disabled channel keeps its fill level.
- At most one channel is popped at a time, and only if it holds a record.
- A waiting word stays stable.
- token_back is a one-cycle pulse and never meets data_ready.

Only the bench scenarios can show:
- which exact count is captured for a given strobe time;
- the bit packing of all four words;
- the drain order across channels and slots;
- slot reuse after the buffer is read empty;
- the behaviour of the flags across load and drain.

// File: rtl/hit_ts_pkg.sv
package hit_ts_pkg;
  localparam int TS_W   = 48;
  localparam int CHIP_W = 2;
  localparam int CHAN_W = 6;
  localparam int SLOT_W = 3;
  localparam int BEAT_W = 16;
  localparam int REC_W  = 64;
  localparam int BEATS  = REC_W / BEAT_W;
  localparam int PAD_W  = REC_W - TS_W - CHIP_W - CHAN_W - SLOT_W - 1;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [CHIP_W-1:0] chip;
    logic [CHAN_W-1:0] chan;
    logic [SLOT_W-1:0] slot;
    logic              anodic;
    logic [PAD_W-1:0]  pad;
  } hit_rec_t;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_SCAN = 2'd1,
    RD_SEND = 2'd2
  } rd_state_e;
endpackage

// File: rtl/gray_ts_counter.sv
module gray_ts_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q, bin_d, gray_d;

  always_comb begin
    bin_d  = bin_q + {{(W-1){1'b0}}, 1'b1};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_o <= gray_d;
    end
  end

  // R1
  gray_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(gray_o ^ $past(gray_o)) == 1));
endmodule

// File: rtl/hit_channel.sv
module hit_channel
  import hit_ts_pkg::*;
#(
  parameter int A_DEPTH = 5,
  parameter int C_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              en_i,
  input  logic              anodic_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              pop_i,
  output logic              avail_o,
  output logic [TS_W-1:0]   head_ts_o,
  output logic [SLOT_W-1:0] head_slot_o
);
  localparam int CW = $clog2(A_DEPTH + 1);

  logic [2:0]           sync_q;
  logic [CW-1:0]        cnt_q, cnt_d, rd_q, rd_d, depth_w;
  logic                 edge_w, full_w, wr_w;
  logic [TS_W-1:0]      mem_q [A_DEPTH];

  always_comb begin
    edge_w  = sync_q[1] & ~sync_q[2];
    depth_w = anodic_i ? CW'(A_DEPTH) : CW'(C_DEPTH);
    full_w  = (cnt_q >= depth_w);
    wr_w    = edge_w & en_i & ~full_w;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    if (wr_w) cnt_d = cnt_q + CW'(1);
    if (pop_i) begin
      if ((rd_q + CW'(1)) == cnt_d) begin
        cnt_d = '0;
        rd_d  = '0;
      end else begin
        rd_d = rd_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strobe_i};
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
    end
  end

  for (genvar s = 0; s < A_DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_w && (cnt_q == CW'(s))) mem_q[s] <= ts_i;
    end
  end

  always_comb begin
    head_ts_o = '0;
    for (int s = 0; s < A_DEPTH; s++) begin
      if (rd_q == CW'(s)) head_ts_o = mem_q[s];
    end
    head_slot_o = SLOT_W'(rd_q);
    avail_o     = (cnt_q != rd_q);
  end

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth_w);
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && full_w && !pop_i) |=> $stable(cnt_q));
  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !pop_i) |=> $stable(cnt_q));
  // R9
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> avail_o);
endmodule

// File: rtl/token_readout.sv
module token_readout
  import hit_ts_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       token_go_i,
  input  logic                       data_read_i,
  input  logic [CHIP_W-1:0]          chip_id_i,
  input  logic [NCH-1:0]             avail_i,
  input  logic [NCH-1:0]             anodic_i,
  input  logic [NCH-1:0][TS_W-1:0]   head_ts_i,
  input  logic [NCH-1:0][SLOT_W-1:0] head_slot_i,
  output logic [NCH-1:0]             pop_o,
  output logic [BEAT_W-1:0]          data_o,
  output logic                       data_ready_o,
  output logic                       token_back_o
);
  localparam int BW = $clog2(BEATS);

  rd_state_e          st_q, st_d;
  logic [CHAN_W-1:0]  sel_q, sel_d, pick_w;
  logic [REC_W-1:0]   rec_q, rec_d;
  logic [BW-1:0]      beat_q, beat_d;
  logic               tb_q, tb_d, found_w, last_w;
  hit_rec_t           rec_w;

  always_comb begin
    pick_w  = '0;
    found_w = |avail_i;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (avail_i[i]) pick_w = CHAN_W'(i);
    end
    rec_w.ts     = head_ts_i[pick_w];
    rec_w.chip   = chip_id_i;
    rec_w.chan   = pick_w;
    rec_w.slot   = head_slot_i[pick_w];
    rec_w.anodic = anodic_i[pick_w];
    rec_w.pad    = '0;
  end

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    rec_d  = rec_q;
    beat_d = beat_q;
    tb_d   = 1'b0;
    last_w = (beat_q == BW'(BEATS - 1));
    case (st_q)
      RD_IDLE: if (token_go_i) st_d = RD_SCAN;
      RD_SCAN: begin
        if (found_w) begin
          rec_d  = rec_w;
          sel_d  = pick_w;
          beat_d = '0;
          st_d   = RD_SEND;
        end else begin
          tb_d = 1'b1;
          st_d = RD_IDLE;
        end
      end
      RD_SEND: begin
        if (data_read_i) begin
          if (last_w) begin
            st_d  = RD_SCAN;
            rec_d = '0;
          end else begin
            beat_d = beat_q + BW'(1);
            rec_d  = rec_q << BEAT_W;
          end
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      sel_q  <= '0;
      rec_q  <= '0;
      beat_q <= '0;
      tb_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      rec_q  <= rec_d;
      beat_q <= beat_d;
      tb_q   <= tb_d;
    end
  end

  always_comb begin
    pop_o        = (st_q == RD_SEND && data_read_i && last_w) ? (NCH'(1) << sel_q) : '0;
    data_o       = rec_q[REC_W-1 -: BEAT_W];
    data_ready_o = (st_q == RD_SEND);
    token_back_o = tb_q;
  end

  // R10
  ready_token_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_ready_o && token_back_o));
  // R10
  token_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_back_o |=> !token_back_o);
  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready_o && !data_read_i) |=> (data_ready_o && $stable(data_o)));
  // R9
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_o));
endmodule

// File: rtl/hit_ts_readout.sv
module hit_ts_readout
  import hit_ts_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int A_DEPTH = 5,
  parameter int C_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic [NCH-1:0]    chan_anodic_i,
  input  logic [CHIP_W-1:0] chip_id_i,
  input  logic              token_go_i,
  input  logic              data_read_i,
  output logic [BEAT_W-1:0] data_o,
  output logic              data_ready_o,
  output logic              token_back_o,
  output logic              anode_nonempty_o,
  output logic              cathode_nonempty_o
);
  logic [1:0]                 rsync_q;
  logic                       rst_int_n;
  logic [TS_W-1:0]            ts_gray;
  logic [NCH-1:0]             avail_w, pop_w;
  logic [NCH-1:0][TS_W-1:0]   head_ts_w;
  logic [NCH-1:0][SLOT_W-1:0] head_slot_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  gray_ts_counter #(.W(TS_W)) ts_cnt_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .gray_o (ts_gray)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    hit_channel #(.A_DEPTH(A_DEPTH), .C_DEPTH(C_DEPTH)) chan_i (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .strobe_i    (hit_i[c]),
      .en_i        (chan_en_i[c]),
      .anodic_i    (chan_anodic_i[c]),
      .ts_i        (ts_gray),
      .pop_i       (pop_w[c]),
      .avail_o     (avail_w[c]),
      .head_ts_o   (head_ts_w[c]),
      .head_slot_o (head_slot_w[c])
    );
  end

  token_readout #(.NCH(NCH)) rdout_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .token_go_i   (token_go_i),
    .data_read_i  (data_read_i),
    .chip_id_i    (chip_id_i),
    .avail_i      (avail_w),
    .anodic_i     (chan_anodic_i),
    .head_ts_i    (head_ts_w),
    .head_slot_i  (head_slot_w),
    .pop_o        (pop_w),
    .data_o       (data_o),
    .data_ready_o (data_ready_o),
    .token_back_o (token_back_o)
  );

  always_comb begin
    anode_nonempty_o   = |(avail_w & chan_anodic_i);
    cathode_nonempty_o = |(avail_w & ~chan_anodic_i);
  end

  // R11
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (anode_nonempty_o || cathode_nonempty_o) |-> (avail_w != '0));
endmodule

// File: tb/hit_ts_readout_tb_top.sv
module hit_ts_readout_tb_top;
  localparam int NCH = 6;
  localparam logic [NCH-1:0] MODE = 6'b010101; // 1 = anodic: ch0, ch2, ch4
  localparam logic [1:0] CHIP = 2'b10;
  localparam int NV = 13;
  // each vector: {channel[3:0], expected kept}
  localparam logic [4:0] VEC [NV] = '{
    {4'd0, 1'b1}, {4'd1, 1'b1}, {4'd2, 1'b1}, {4'd0, 1'b1}, {4'd5, 1'b0},
    {4'd3, 1'b1}, {4'd0, 1'b1}, {4'd1, 1'b0}, {4'd4, 1'b1}, {4'd0, 1'b1},
    {4'd0, 1'b1}, {4'd0, 1'b0}, {4'd2, 1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] hit, en;
  logic token_go, data_read;
  logic [15:0] data_o;
  logic data_ready, token_back, a_ne, c_ne;

  int nchk = 0, nfail = 0, cyc = 0;
  logic finished = 1'b0;
  longint mb [NCH][8];
  int mcnt [NCH];
  logic [63:0] exp_rec [32];
  longint exp_bin [32];
  int n_exp;

  always #2 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  hit_ts_readout dut_i (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .chan_en_i(en),
    .chan_anodic_i(MODE), .chip_id_i(CHIP), .token_go_i(token_go),
    .data_read_i(data_read), .data_o(data_o), .data_ready_o(data_ready),
    .token_back_o(token_back), .anode_nonempty_o(a_ne),
    .cathode_nonempty_o(c_ne));

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [47:0] to_gray(input longint b);
    logic [47:0] v = b[47:0];
    return v ^ (v >> 1);
  endfunction

  function automatic longint from_gray(input logic [47:0] g);
    logic [47:0] b;
    b[47] = g[47];
    for (int i = 46; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return longint'(b);
  endfunction

  task automatic hit_pulse(input int ch, input logic kept);
    @(negedge clk);
    hit[ch] = 1'b1;
    if (kept) begin
      mb[ch][mcnt[ch]] = cyc;
      mcnt[ch]++;
    end
    repeat (2) @(negedge clk);
    hit[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic build_exp();
    n_exp = 0;
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < mcnt[c]; s++) begin
        exp_rec[n_exp] = {to_gray(mb[c][s]), CHIP, 6'(c), 3'(s), MODE[c], 4'b0000};
        exp_bin[n_exp] = mb[c][s];
        n_exp++;
      end
      mcnt[c] = 0;
    end
  endtask

  // R9 R10: one token visit, records checked beat by beat in expected order
  task automatic drain();
    int nrec = 0, beat = 0, guard = 0;
    logic done = 1'b0;
    logic [63:0] acc = '0;
    logic [15:0] w;
    build_exp();
    @(negedge clk); token_go = 1'b1;
    @(negedge clk); token_go = 1'b0;
    while (!done && guard < 2000) begin
      guard++;
      if (token_back) done = 1'b1;
      else if (data_ready) begin
        w = data_o;
        if (nrec < n_exp)
          chk(w == exp_rec[nrec][63-16*beat -: 16], "R3/R4 beat", longint'(w),
              longint'(exp_rec[nrec][63-16*beat -: 16]));
        @(negedge clk);
        chk(data_ready && data_o == w, "R4 hold", longint'(data_o), longint'(w));
        data_read = 1'b1;
        @(negedge clk);
        data_read = 1'b0;
        acc = {acc[47:0], w};
        beat++;
        if (beat == 4) begin
          if (nrec < n_exp)
            chk(from_gray(acc[63:16]) == exp_bin[nrec], "R2 timestamp",
                from_gray(acc[63:16]), exp_bin[nrec]);
          beat = 0;
          nrec++;
        end
      end else @(negedge clk);
    end
    chk(done, "R10 token_back", longint'(done), 1);
    chk(nrec == n_exp, "R9 record count", nrec, n_exp);
    @(negedge clk);
    chk(!token_back, "R10 pulse width", longint'(token_back), 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hit = '0; en = 6'b011111; token_go = 1'b0; data_read = 1'b0;
    for (int c = 0; c < NCH; c++) mcnt[c] = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({data_ready, token_back, a_ne, c_ne} == 4'b0, "R12 flags in reset",
        longint'({data_ready, token_back, a_ne, c_ne}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({data_ready, token_back, a_ne, c_ne} == 4'b0 && data_o == 16'h0, "R12 after reset",
        longint'({data_ready, token_back, a_ne, c_ne}), 0);

    // R10 empty visit: token_back two edges after token_go sampled
    @(negedge clk); token_go = 1'b1;
    @(negedge clk); token_go = 1'b0;
    chk(!token_back, "R10 early", longint'(token_back), 0);
    @(negedge clk);
    chk(token_back && !data_ready, "R10 empty token_back", longint'(token_back), 1);
    @(negedge clk);

    // vector table: R5 R6 R7 R8 (ch5 disabled, ch0 sixth hit and ch1 second hit dropped)
    for (int v = 0; v < NV; v++) hit_pulse(int'(VEC[v][4:1]), VEC[v][0]);
    repeat (4) @(negedge clk);
    chk(a_ne && c_ne, "R11 both flags", longint'({a_ne, c_ne}), 3);
    drain();
    chk(!a_ne && !c_ne, "R11 flags after drain", longint'({a_ne, c_ne}), 0);

    // R11 cathodic only
    hit_pulse(3, 1'b1);
    repeat (4) @(negedge clk);
    chk(!a_ne && c_ne, "R11 cathodic only", longint'({a_ne, c_ne}), 1);
    drain();

    // R5 slot reuse after the channel was read empty
    hit_pulse(4, 1'b1);
    hit_pulse(4, 1'b1);
    repeat (4) @(negedge clk);
    chk(a_ne && !c_ne, "R11 anodic only", longint'({a_ne, c_ne}), 2);
    drain();

    // R8 disabled channel leaves flags low
    en = 6'b000000;
    hit_pulse(2, 1'b0);
    repeat (4) @(negedge clk);
    chk(!a_ne && !c_ne, "R8 disabled", longint'({a_ne, c_ne}), 0);
    drain();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule